// File: doc/BRIEF.md
# Sorted Edge Delta Codec

This block shrinks a sorted stream of 29-bit graph endpoint values that belong to one bucket. Each value is treated as a 7-bit high part and a 22-bit low part. The encoder stores only the 22-bit low part of each value. It packs these fields end to end into 32-bit words. At the end of the bucket it writes out the last, partly filled word.

The decoder reads the packed words and cuts them back into 22-bit fields. It rebuilds each full value from the value before it. It keeps that earlier value's high part. It adds one to the high part when the new field is smaller than the earlier low part. This works only because the values come in sorted order and no two neighbours are 2^22 or more apart.

Both directions use valid/ready handshakes and have their own start pulse for each bucket. The encoder counts the values it has taken. The decoder is given that count and stops once it has rebuilt that many values.

Top module: `edge_delta_codec`

## Requirements
- R1: The field of value k (its bits 21:0) fills stream bits 22k to 22k+21, starting with its least significant bit. Stream bit j is bit j mod 32 of packed word j div 32, and words leave in stream order.
- R2: An end-of-bucket pulse makes the encoder emit the partly filled word, with its unused upper bits set to zero. A bucket of n values therefore yields exactly ceil(22n/32) words.
- R3: Each bucket starts with a previous value of 0. The encoder sets enc_err in the cycle after it accepts a value that is either smaller than the previous value or at least 2^22 above it. A step of exactly 2^22-1 does not set the flag. enc_err stays set until the next enc_start.
- R4: enc_count reads zero after reset and after enc_start, and goes up by one for each value accepted.
- R5: Each decoded value equals the previous decoded value with its low 22 bits replaced by the field. Its high 7 bits are raised by one when the field is smaller than the previous low 22 bits. The previous value is 0 at dec_start.
- R6: After dec_start with a count N, the decoder takes exactly ceil(22N/32) words and emits exactly N values, then raises dec_done. While dec_done is high, dec_word_ready stays low, and N = 0 gives dec_done at once.
- R7: The cycle after an end-of-bucket pulse, enc_in_ready is low. An end pulse that arrives together with the acceptance of a value still includes that value in the flushed output.
- R8: An output that is valid but not accepted keeps its valid and its data unchanged into the next cycle, on both the encoder word port and the decoder value port.
- R9: After reset, no output is valid, enc_err is low, enc_in_ready is high and dec_done is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| enc_start | input | 1 | Begin a new encoder bucket |
| enc_last | input | 1 | End-of-bucket pulse; flush the partial word |
| enc_in_valid | input | 1 | Input value valid |
| enc_in_value | input | 29 | Sorted endpoint value |
| enc_in_ready | output | 1 | Encoder accepts a value |
| enc_word_valid | output | 1 | Packed word valid |
| enc_word_data | output | 32 | Packed word |
| enc_word_ready | input | 1 | Sink takes the packed word |
| enc_count | output | CNT_W | Values accepted in this bucket |
| enc_err | output | 1 | Step rule broken in this bucket (sticky) |
| dec_start | input | 1 | Begin a new decoder bucket |
| dec_total | input | CNT_W | Values to decode, sampled at dec_start |
| dec_word_valid | input | 1 | Packed word valid |
| dec_word_data | input | 32 | Packed word |
| dec_word_ready | output | 1 | Decoder takes a word |
| dec_out_valid | output | 1 | Rebuilt value valid |
| dec_out_value | output | 29 | Rebuilt endpoint value |
| dec_out_ready | input | 1 | Sink takes the value |
| dec_done | output | 1 | All requested values rebuilt |

## Verification
Two encoder events can fall in the same cycle: the acceptance of the final value of a bucket and the end-of-bucket pulse. The bench causes this on every other table bucket. It raises enc_last in the same pre-edge window in which it sees enc_in_ready high for the final value. It judges the outcome in three ways: the word count must still be ceil(22n/32), the last word must hold the final field with zero padding, and enc_in_ready must be low in the following cycle. A second overlap, a packed word leaving while a new field fills the accumulator, is driven with random backpressure on the word port.

// File: rtl/edc_pkg.sv
package edc_pkg;
  localparam int VAL_W  = 29;
  localparam int LOW_W  = 22;
  localparam int HIGH_W = VAL_W - LOW_W;
  localparam int WORD_W = 32;
  localparam int ACC_W  = WORD_W + LOW_W;
  localparam int FILL_W = $clog2(ACC_W + 1);

  localparam logic [VAL_W:0] STEP_LIM = (VAL_W + 1)'({1'b1, {LOW_W{1'b0}}});

  function automatic logic [LOW_W-1:0] low_part(input logic [VAL_W-1:0] v);
    return v[LOW_W-1:0];
  endfunction

  // true when cur cannot be rebuilt from prev by carry inference
  function automatic logic step_bad(input logic [VAL_W-1:0] prev,
                                    input logic [VAL_W-1:0] cur);
    logic [VAL_W:0] d;
    d = {1'b0, cur} - {1'b0, prev};
    return (cur < prev) || (d >= STEP_LIM);
  endfunction

  function automatic logic [VAL_W-1:0] splice(input logic [VAL_W-1:0] prev,
                                              input logic [LOW_W-1:0] field);
    logic [HIGH_W-1:0] hi;
    hi = prev[VAL_W-1:LOW_W] + HIGH_W'(field < prev[LOW_W-1:0]);
    return {hi, field};
  endfunction
endpackage

// File: rtl/edc_enc.sv
module edc_enc
  import edc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              last,
  input  logic              in_valid,
  input  logic [VAL_W-1:0]  in_value,
  output logic              in_ready,
  output logic              word_valid,
  output logic [WORD_W-1:0] word_data,
  input  logic              word_ready,
  output logic [CNT_W-1:0]  count,
  output logic              err,
  output logic              ev_accept,
  output logic              ev_emit,
  output logic              ev_flush
);
  logic [ACC_W-1:0]  acc;
  logic [FILL_W-1:0] fill;
  logic [VAL_W-1:0]  prev;
  logic              flush_pend;
  logic              slot_free;
  logic [ACC_W-1:0]  merged;
  logic [FILL_W-1:0] fill_sum;

  assign slot_free = !word_valid || word_ready;
  assign in_ready  = !start && !flush_pend && slot_free;
  assign ev_accept = in_valid && in_ready;
  assign merged    = acc | (ACC_W'(low_part(in_value)) << fill);
  assign fill_sum  = fill + FILL_W'(LOW_W);
  assign ev_emit   = ev_accept && (fill_sum >= FILL_W'(WORD_W));
  assign ev_flush  = !start && flush_pend && slot_free;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc        <= '0;
      fill       <= '0;
      prev       <= '0;
      flush_pend <= 1'b0;
      word_valid <= 1'b0;
      word_data  <= '0;
      count      <= '0;
      err        <= 1'b0;
    end else begin
      if (word_valid && word_ready) word_valid <= 1'b0;
      if (start) begin
        acc        <= '0;
        fill       <= '0;
        prev       <= '0;
        flush_pend <= 1'b0;
        count      <= '0;
        err        <= 1'b0;
      end else begin
        if (ev_accept) begin
          prev  <= in_value;
          count <= count + 1'b1;
          if (step_bad(prev, in_value)) err <= 1'b1;
          if (ev_emit) begin
            word_data  <= merged[WORD_W-1:0];
            word_valid <= 1'b1;
            acc        <= merged >> WORD_W;
            fill       <= fill_sum - FILL_W'(WORD_W);
          end else begin
            acc  <= merged;
            fill <= fill_sum;
          end
        end
        if (last) flush_pend <= 1'b1;
        if (ev_flush) begin
          flush_pend <= 1'b0;
          if (fill != '0) begin
            word_data  <= acc[WORD_W-1:0];
            word_valid <= 1'b1;
            acc        <= '0;
            fill       <= '0;
          end
        end
      end
    end
  end
endmodule

// File: rtl/edc_dec.sv
module edc_dec
  import edc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [CNT_W-1:0]  total,
  input  logic              word_valid,
  input  logic [WORD_W-1:0] word_data,
  output logic              word_ready,
  output logic              out_valid,
  output logic [VAL_W-1:0]  out_value,
  input  logic              out_ready,
  output logic              done,
  output logic              ev_take,
  output logic              ev_emit
);
  logic [ACC_W-1:0]  acc;
  logic [FILL_W-1:0] fill;
  logic [CNT_W-1:0]  remain;
  logic [VAL_W-1:0]  prev;
  logic              have_field;
  logic [VAL_W-1:0]  next_val;

  assign done       = (remain == '0);
  assign have_field = (fill >= FILL_W'(LOW_W));
  assign word_ready = !start && !done && !have_field;
  assign ev_take    = word_valid && word_ready;
  assign ev_emit    = !start && !done && have_field && (!out_valid || out_ready);
  assign next_val   = splice(prev, acc[LOW_W-1:0]);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc       <= '0;
      fill      <= '0;
      remain    <= '0;
      prev      <= '0;
      out_valid <= 1'b0;
      out_value <= '0;
    end else begin
      if (out_valid && out_ready) out_valid <= 1'b0;
      if (start) begin
        acc    <= '0;
        fill   <= '0;
        remain <= total;
        prev   <= '0;
      end else begin
        if (ev_take) begin
          acc  <= acc | (ACC_W'(word_data) << fill);
          fill <= fill + FILL_W'(WORD_W);
        end
        if (ev_emit) begin
          acc       <= acc >> LOW_W;
          fill      <= fill - FILL_W'(LOW_W);
          remain    <= remain - 1'b1;
          prev      <= next_val;
          out_value <= next_val;
          out_valid <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/edge_delta_codec.sv
module edge_delta_codec
  import edc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enc_start,
  input  logic              enc_last,
  input  logic              enc_in_valid,
  input  logic [VAL_W-1:0]  enc_in_value,
  output logic              enc_in_ready,
  output logic              enc_word_valid,
  output logic [WORD_W-1:0] enc_word_data,
  input  logic              enc_word_ready,
  output logic [CNT_W-1:0]  enc_count,
  output logic              enc_err,
  input  logic              dec_start,
  input  logic [CNT_W-1:0]  dec_total,
  input  logic              dec_word_valid,
  input  logic [WORD_W-1:0] dec_word_data,
  output logic              dec_word_ready,
  output logic              dec_out_valid,
  output logic [VAL_W-1:0]  dec_out_value,
  input  logic              dec_out_ready,
  output logic              dec_done
);
  // internal events brought out for the checker
  logic ev_enc_accept;
  logic ev_enc_emit;
  logic ev_enc_flush;
  logic ev_dec_take;
  logic ev_dec_emit;

  edc_enc #(.CNT_W(CNT_W)) u_enc (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (enc_start),
    .last       (enc_last),
    .in_valid   (enc_in_valid),
    .in_value   (enc_in_value),
    .in_ready   (enc_in_ready),
    .word_valid (enc_word_valid),
    .word_data  (enc_word_data),
    .word_ready (enc_word_ready),
    .count      (enc_count),
    .err        (enc_err),
    .ev_accept  (ev_enc_accept),
    .ev_emit    (ev_enc_emit),
    .ev_flush   (ev_enc_flush)
  );

  edc_dec #(.CNT_W(CNT_W)) u_dec (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (dec_start),
    .total      (dec_total),
    .word_valid (dec_word_valid),
    .word_data  (dec_word_data),
    .word_ready (dec_word_ready),
    .out_valid  (dec_out_valid),
    .out_value  (dec_out_value),
    .out_ready  (dec_out_ready),
    .done       (dec_done),
    .ev_take    (ev_dec_take),
    .ev_emit    (ev_dec_emit)
  );
endmodule

// File: rtl/edc_checker.sv
module edc_checker
  import edc_pkg::*;
#(
  parameter int CNT_W = 24
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enc_start,
  input logic              enc_last,
  input logic              enc_in_ready,
  input logic              enc_word_valid,
  input logic [WORD_W-1:0] enc_word_data,
  input logic              enc_word_ready,
  input logic [CNT_W-1:0]  enc_count,
  input logic              enc_err,
  input logic              dec_word_ready,
  input logic              dec_out_valid,
  input logic [VAL_W-1:0]  dec_out_value,
  input logic              dec_out_ready,
  input logic              dec_done,
  input logic              ev_enc_accept
);
  AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    enc_word_valid && !enc_word_ready |=> enc_word_valid && $stable(enc_word_data)); // R8
  AST_VALUE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    dec_out_valid && !dec_out_ready |=> dec_out_valid && $stable(dec_out_value)); // R8
  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ev_enc_accept |=> enc_count == $past(enc_count) + 1'b1); // R4
  AST_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    enc_start |=> enc_count == '0); // R4
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    enc_err && !enc_start |=> enc_err); // R3
  AST_ERR_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    enc_start |=> !enc_err); // R3
  AST_FLUSH_BLOCK: assert property (@(posedge clk) disable iff (!rst_n)
    enc_last && !enc_start |=> !enc_in_ready); // R7
  AST_DONE_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    dec_done |-> !dec_word_ready); // R6
endmodule

bind edge_delta_codec edc_checker #(.CNT_W(CNT_W)) i_edc_checker (
  .clk            (clk),
  .rst_n          (rst_n),
  .enc_start      (enc_start),
  .enc_last       (enc_last),
  .enc_in_ready   (enc_in_ready),
  .enc_word_valid (enc_word_valid),
  .enc_word_data  (enc_word_data),
  .enc_word_ready (enc_word_ready),
  .enc_count      (enc_count),
  .enc_err        (enc_err),
  .dec_word_ready (dec_word_ready),
  .dec_out_valid  (dec_out_valid),
  .dec_out_value  (dec_out_value),
  .dec_out_ready  (dec_out_ready),
  .dec_done       (dec_done),
  .ev_enc_accept  (ev_enc_accept)
);

// File: tb/test_edge_delta_codec.sv
module test_edge_delta_codec;
  localparam int CLK_PERIOD = 10;
  localparam int CW = 24;
  localparam int NT = 6;
  // bucket size, first value, largest step, expected word count
  localparam int TBL_N     [NT] = '{1, 16, 17, 40, 64, 3};
  localparam int TBL_START [NT] = '{0, 1000, 4194000, 12345, 4194303, 0};
  localparam int TBL_STEP  [NT] = '{0, 0, 300, 4000000, 4194303, 1};
  localparam int TBL_WORDS [NT] = '{1, 11, 12, 28, 44, 3};

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        enc_start = 0, enc_last = 0, enc_in_valid = 0;
  logic [28:0] enc_in_value = '0;
  logic        enc_in_ready, enc_word_valid, enc_err;
  logic [31:0] enc_word_data;
  logic        enc_word_ready = 0;
  logic [CW-1:0] enc_count;
  logic        dec_start = 0, dec_word_valid = 0, dec_out_ready = 0;
  logic [CW-1:0] dec_total = '0;
  logic [31:0] dec_word_data = '0;
  logic        dec_word_ready, dec_out_valid, dec_done;
  logic [28:0] dec_out_value;

  int checks = 0;
  int errors = 0;
  int unsigned seed = 32'h1234_5678;
  int cyc = 0;
  logic [28:0] vals [0:127];
  logic [31:0] words [0:128];
  int nw_got;

  edge_delta_codec #(.CNT_W(CW)) i_edge_delta_codec (.*);

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; errors++;
      $display("FAIL R6 watchdog expired: actual %0d cycles, expected fewer", cyc);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic gen(input int n, input int start, input int step);
    vals[0] = 29'(start);
    for (int k = 1; k < n; k++) begin
      int unsigned d;
      d = (k == 1) ? step : rnd() % (step + 1);
      vals[k] = vals[k-1] + 29'(d);
    end
  endtask

  // bench model of the packed stream
  function automatic logic [31:0] model_word(input int w, input int n);
    logic [31:0] r;
    r = '0;
    for (int b = 0; b < 32; b++) begin
      int j;
      j = w * 32 + b;
      if (j < 22 * n) r[b] = vals[j / 22][j % 22];
    end
    return r;
  endfunction

  task automatic pulse_enc_start();
    @(negedge clk); enc_start = 1'b1;
    @(negedge clk); enc_start = 1'b0;
  endtask

  task automatic run_enc(input int n, input bit coincide, input bit bp);
    int idx;
    bit ended, blk;
    idx = 0; ended = 0; blk = 0; nw_got = 0;
    pulse_enc_start();
    for (int c = 0; c < n * 4 + 40; c++) begin
      @(negedge clk);
      enc_last = 1'b0;
      enc_word_ready = bp ? ((rnd() & 3) != 0) : 1'b1;
      enc_in_valid = (idx < n);
      enc_in_value = (idx < n) ? vals[idx] : '0;
      #1;
      if (blk) begin
        check(!enc_in_ready, "R7", "ready after end pulse", enc_in_ready, 0);
        blk = 0;
      end
      if (enc_word_valid && enc_word_ready && nw_got < 128) begin
        words[nw_got] = enc_word_data;
        nw_got++;
      end
      if (enc_in_valid && enc_in_ready) begin
        if (coincide && idx == n - 1) begin enc_last = 1'b1; ended = 1; blk = 1; end
        idx++;
      end else if (!ended && idx == n) begin
        enc_last = 1'b1; ended = 1; blk = 1;
      end
    end
    @(negedge clk);
    enc_last = 1'b0; enc_in_valid = 1'b0; enc_word_ready = 1'b0;
  endtask

  task automatic run_dec(input int n, input int nw, input bit bp);
    int widx, k;
    widx = 0; k = 0;
    words[nw] = 32'hFFFF_FFFF;
    @(negedge clk); dec_start = 1'b1; dec_total = CW'(n);
    @(negedge clk); dec_start = 1'b0;
    for (int c = 0; c < nw * 3 + n * 3 + 40; c++) begin
      @(negedge clk);
      dec_out_ready = bp ? ((rnd() & 3) != 0) : 1'b1;
      dec_word_valid = (widx <= nw);
      dec_word_data = words[widx];
      #1;
      if (dec_word_valid && dec_word_ready) widx++;
      if (dec_out_valid && dec_out_ready) begin
        if (k < n)
          check(dec_out_value == vals[k], "R5", "decoded value", dec_out_value, vals[k]);
        k++;
      end
    end
    @(negedge clk);
    dec_word_valid = 1'b0; dec_out_ready = 1'b0;
    #1;
    check(k == n, "R6", "values emitted", k, n);
    check(widx == nw, "R6", "words consumed", widx, nw);
    check(dec_done, "R6", "done after bucket", dec_done, 1);
  endtask

  task automatic send_one(input logic [28:0] v);
    @(negedge clk);
    enc_in_valid = 1'b1; enc_in_value = v; enc_word_ready = 1'b1;
    #1;
    while (!enc_in_ready) begin @(negedge clk); #1; end
    @(negedge clk);
    enc_in_valid = 1'b0;
    #1;
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R9: reset state
    check(!enc_word_valid, "R9", "word valid", enc_word_valid, 0);
    check(!dec_out_valid, "R9", "value valid", dec_out_valid, 0);
    check(!enc_err, "R9", "err", enc_err, 0);
    check(enc_in_ready, "R9", "in ready", enc_in_ready, 1);
    check(dec_done, "R9", "dec done", dec_done, 1);
    check(enc_count == 0, "R4", "count at reset", enc_count, 0);

    for (int t = 0; t < NT; t++) begin
      gen(TBL_N[t], TBL_START[t], TBL_STEP[t]);
      run_enc(TBL_N[t], (t % 2) == 1, t >= 2);
      check(nw_got == TBL_WORDS[t], "R2", "word count", nw_got, TBL_WORDS[t]);
      for (int w = 0; w < nw_got && w < TBL_WORDS[t]; w++)
        check(words[w] == model_word(w, TBL_N[t]), "R1", "packed word",
              words[w], model_word(w, TBL_N[t]));
      check(enc_count == CW'(TBL_N[t]), "R4", "count after bucket", enc_count, TBL_N[t]);
      check(!enc_err, "R3", "no error for legal steps", enc_err, 0);
      run_dec(TBL_N[t], nw_got, t >= 3);
    end

    // R3: step limit and sticky error
    pulse_enc_start();
    send_one(29'd5);
    check(!enc_err, "R3", "first small value", enc_err, 0);
    send_one(29'd5 + 29'd4194303);
    check(!enc_err, "R3", "step 2^22-1 allowed", enc_err, 0);
    send_one(29'd5 + 29'd4194303 + 29'd4194304);
    check(enc_err, "R3", "step 2^22 flagged", enc_err, 1);
    send_one(29'd5 + 29'd4194303 + 29'd4194305);
    check(enc_err, "R3", "error sticky", enc_err, 1);
    pulse_enc_start();
    #1;
    check(!enc_err, "R3", "error cleared by start", enc_err, 0);
    check(enc_count == 0, "R4", "count cleared by start", enc_count, 0);
    send_one(29'd4194304);
    check(enc_err, "R3", "first value upper bits set", enc_err, 1);
    pulse_enc_start();
    send_one(29'd100);
    send_one(29'd99);
    check(enc_err, "R3", "decreasing value", enc_err, 1);
    check(enc_count == 2, "R4", "count of two", enc_count, 2);

    // R6: zero-length decode
    @(negedge clk); dec_start = 1'b1; dec_total = '0;
    @(negedge clk); dec_start = 1'b0; dec_word_valid = 1'b1; dec_word_data = 32'h0;
    #1;
    check(dec_done && !dec_word_ready, "R6", "empty bucket takes no word",
          dec_word_ready, 0);
    @(negedge clk); dec_word_valid = 1'b0;
    #1;
    check(!dec_out_valid, "R6", "empty bucket emits nothing", dec_out_valid, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule